// File: doc/BRIEF.md
# Addressable Phase Word Bank

This block keeps a bank of addressed 32-bit tuning words for a frequency synthesizer and hands one of them to a downstream serial writer on command. A word is built in a staging register from two 16-bit halves delivered by successive load commands. A final load command with the write-enable bit set commits the staged word into the entry named by a 4-bit address. Staging is kept apart from the bank, so a half-built word never disturbs a stored entry.

A pulse command reads the addressed entry and presents it as a payload together with a one-cycle valid strobe. After a fixed delay of `DELAY` cycles (4 by default), the block raises a one-cycle update request. This lets the synthesizer switch to the stored frequency or phase at a known instant. The delay is sequenced by a small state machine with two states:
- `S_IDLE`: no delay is running.
- `S_COUNT`: a delay is counting down.

The machine has these transitions:
- `S_IDLE`→`S_COUNT` when a pulse arrives.
- `S_COUNT`→`S_COUNT` on every tick while the count is running.
- `S_COUNT`→`S_COUNT` when a new pulse arrives, which restarts the count.
- `S_COUNT`→`S_IDLE` when the count expires, at which point the update request is issued.

Top module: `phase_bank_top`

## Requirements
- R1: After reset, `payload`, `payload_valid` and `update_req` are 0, and every bank entry reads back as 0 through a pulse.
- R2: `load_cmd` with `wr_en`=0 and `set_cur`=0 writes `data_in` into staging bits 15:0 and leaves bits 31:16 unchanged.
- R3: `load_cmd` with `wr_en`=0 and `set_cur`=1 writes `data_in` into staging bits 31:16 and leaves bits 15:0 unchanged.
- R4: `load_cmd` with `wr_en`=1 and `set_cur`=1 copies the staged word into the entry at `addr`. During this command `data_in` is ignored, the staging register is unchanged, and all other entries are unchanged.
- R5: `load_cmd` with `wr_en`=1 and `set_cur`=0 has no effect on the staging register or on the bank.
- R6: Writing staging halves does not change any stored bank entry.
- R7: When `pulse_cmd` is sampled high, `payload` equals the entry at `addr` in the next cycle, and `payload_valid` is high for exactly that one cycle. Between pulses, `payload` holds its value.
- R8: `update_req` is high for exactly one cycle, `DELAY` cycles (default 4) after the `payload_valid` cycle of the pulse that started the delay. It stays low in the cycles between.
- R9: A pulse that arrives while a delay is counting restarts the delay, outputs the new address's entry, and yields a single `update_req` exactly `DELAY` cycles after the latest `payload_valid`.
- R10: A pulse sampled in the same cycle as a commit to the same address outputs the entry's previous contents. The new contents appear on the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_cmd | input | 1 | Load command strobe |
| pulse_cmd | input | 1 | Pulse command strobe |
| data_in | input | 16 | Half-word data field |
| wr_en | input | 1 | Commit-to-bank select for load |
| set_cur | input | 1 | Upper-half select / commit qualifier |
| addr | input | 4 | Bank entry address |
| payload | output | 32 | Word handed to the serial writer |
| payload_valid | output | 1 | One-cycle strobe marking a new payload |
| update_req | output | 1 | One-cycle delayed update request |

## Verification
A corrupted staging half does not show at the ports when the half is written. It appears only after a commit and a later pulse, so each staging check is followed by a commit and a read-back of a fresh entry. A wrong bank entry shows in `payload` one cycle after the pulse that reads it. A wrong delay count or state shows as `update_req` arriving a cycle early, arriving late, arriving twice, or missing after a retrigger, so every pulse is followed by a cycle-exact watch of the whole delay window.

// File: rtl/phase_bank_pkg.sv
package phase_bank_pkg;
    typedef enum logic {
        S_IDLE  = 1'b0,
        S_COUNT = 1'b1
    } dly_state_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOWER  = 2'd1,
        OP_UPPER  = 2'd2,
        OP_COMMIT = 2'd3
    } load_op_t;

    function automatic load_op_t decode_load(input logic ld, input logic we, input logic sc);
        if (!ld)            return OP_NONE;
        else if (!we && !sc) return OP_LOWER;
        else if (!we && sc)  return OP_UPPER;
        else if (we && sc)   return OP_COMMIT;
        else                 return OP_NONE;
    endfunction
endpackage

// File: rtl/phase_word_stage.sv
module phase_word_stage
    import phase_bank_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  load_op_t          op,
    input  logic [HALF_W-1:0] half_in,
    output logic [WORD_W-1:0] staged
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else begin
            unique case (op)
                OP_LOWER: staged[HALF_W-1:0]      <= half_in;
                OP_UPPER: staged[WORD_W-1:HALF_W] <= half_in;
                default:  staged                  <= staged;
            endcase
        end
    end

    a_r2_lower_only: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOWER |=> staged[HALF_W-1:0] == $past(half_in)
                           && $stable(staged[WORD_W-1:HALF_W]));
    a_r3_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_UPPER |=> staged[WORD_W-1:HALF_W] == $past(half_in)
                           && $stable(staged[HALF_W-1:0]));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE || op == OP_COMMIT) |=> $stable(staged));
endmodule

// File: rtl/phase_reg_file.sv
module phase_reg_file #(
    parameter int WORD_W = 32,
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[i] <= '0;
            else if (we && waddr == ADDR_W'(i))
                entry[i] <= wdata;
        end

        a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == ADDR_W'(i)) |=> $stable(entry[i]));
    end

    assign rdata = entry[raddr];
endmodule

// File: rtl/pulse_delay_fsm.sv
module pulse_delay_fsm
    import phase_bank_pkg::*;
#(
    parameter int DELAY = 4,
    localparam int CNT_W = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic valid,
    output logic update
);
    dly_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic expire;

    assign expire = (state == S_COUNT) && (cnt == CNT_W'(1)) && !pulse;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (pulse) state_nx = S_COUNT;
            S_COUNT: if (expire) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            valid  <= 1'b0;
            update <= 1'b0;
        end else begin
            valid  <= pulse;
            update <= expire;
            if (pulse)                 cnt <= CNT_W'(DELAY);
            else if (state == S_COUNT) cnt <= cnt - CNT_W'(1);
            else                       cnt <= '0;
        end
    end

    a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_COUNT |-> cnt != '0);
    a_r8_update_single: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> !update);
    a_r9_restart_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !update && state == S_COUNT);
    a_r7_valid_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(pulse));
endmodule

// File: rtl/phase_bank_top.sv
module phase_bank_top
    import phase_bank_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int DEPTH = 16,
    parameter int DELAY = 4,
    localparam int WORD_W = 2 * HALF_W,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cmd,
    input  logic              pulse_cmd,
    input  logic [HALF_W-1:0] data_in,
    input  logic              wr_en,
    input  logic              set_cur,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] payload,
    output logic              payload_valid,
    output logic              update_req
);
    load_op_t          op;
    logic [WORD_W-1:0] staged;
    logic [WORD_W-1:0] rd_word;

    assign op = decode_load(load_cmd, wr_en, set_cur);

    phase_word_stage #(.HALF_W(HALF_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .op(op), .half_in(data_in), .staged(staged)
    );

    phase_reg_file #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(op == OP_COMMIT), .waddr(addr),
        .wdata(staged), .raddr(addr), .rdata(rd_word)
    );

    pulse_delay_fsm #(.DELAY(DELAY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pulse(pulse_cmd),
        .valid(payload_valid), .update(update_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         payload <= '0;
        else if (pulse_cmd) payload <= rd_word;
    end

    a_r7_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !payload_valid |-> $stable(payload));
    a_r6_stage_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_cmd && (op == OP_LOWER || op == OP_UPPER)) |=> payload == $past(rd_word));
endmodule

// File: tb/tb_phase_bank_top.sv
module tb_phase_bank_top;
    localparam int DELAY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_cmd = 1'b0, pulse_cmd = 1'b0, wr_en = 1'b0, set_cur = 1'b0;
    logic [15:0] data_in = '0;
    logic [3:0]  addr = '0;
    logic [31:0] payload;
    logic        payload_valid, update_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    phase_bank_top dut (
        .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .pulse_cmd(pulse_cmd),
        .data_in(data_in), .wr_en(wr_en), .set_cur(set_cur), .addr(addr),
        .payload(payload), .payload_valid(payload_valid), .update_req(update_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic we, input logic sc, input logic [3:0] a, input logic [15:0] d);
        load_cmd = 1'b1; wr_en = we; set_cur = sc; addr = a; data_in = d;
        @(negedge clk);
        load_cmd = 1'b0; wr_en = 1'b0; set_cur = 1'b0;
    endtask

    task automatic store_word(input logic [3:0] a, input logic [31:0] w);
        load(1'b0, 1'b0, a, w[15:0]);
        load(1'b0, 1'b1, a, w[31:16]);
        load(1'b1, 1'b1, a, 16'hDEAD);
    endtask

    // pulse, check payload and valid, then the whole delay window
    task automatic pulse_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        pulse_cmd = 1'b1; addr = a;
        @(negedge clk);
        pulse_cmd = 1'b0;
        check({req, " payload"}, payload, exp);
        check("R7 valid high", 32'(payload_valid), 32'd1);
        for (int i = 1; i < DELAY; i++) begin
            @(negedge clk);
            check("R8 update early", 32'(update_req), 32'd0);
            if (i == 1) check("R7 valid one cycle", 32'(payload_valid), 32'd0);
            check("R7 payload held", payload, exp);
        end
        @(negedge clk);
        check("R8 update on time", 32'(update_req), 32'd1);
        @(negedge clk);
        check("R8 update one cycle", 32'(update_req), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 payload", payload, 32'h0);
        check("R1 valid", 32'(payload_valid), 32'd0);
        check("R1 update", 32'(update_req), 32'd0);
        pulse_check("R1 entry zero", 4'd5, 32'h0);
    endtask

    task automatic t_store_read();
        store_word(4'd3, 32'hA1B2_C3D4);
        pulse_check("R2 R3 R4 stored word", 4'd3, 32'hA1B2_C3D4);
        pulse_check("R4 other entry kept", 4'd4, 32'h0);
        store_word(4'd15, 32'h1357_9BDF);
        pulse_check("R4 top entry", 4'd15, 32'h1357_9BDF);
    endtask

    task automatic t_halves_isolated();
        load(1'b0, 1'b0, 4'd3, 16'h5555);
        load(1'b0, 1'b1, 4'd3, 16'h6666);
        pulse_check("R6 halves leave bank", 4'd3, 32'hA1B2_C3D4);
        load(1'b0, 1'b0, 4'd3, 16'h7777);
        load(1'b1, 1'b1, 4'd7, 16'h0000);
        pulse_check("R2 lower only rewritten", 4'd7, 32'h6666_7777);
        load(1'b0, 1'b1, 4'd3, 16'h8888);
        load(1'b1, 1'b1, 4'd8, 16'hFFFF);
        pulse_check("R3 upper only rewritten", 4'd8, 32'h8888_7777);
    endtask

    task automatic t_ignored();
        load(1'b1, 1'b0, 4'd3, 16'h1234);
        pulse_check("R5 bank untouched", 4'd3, 32'hA1B2_C3D4);
        load(1'b1, 1'b1, 4'd9, 16'h4321);
        pulse_check("R5 staging untouched", 4'd9, 32'h8888_7777);
    endtask

    task automatic t_retrigger();
        pulse_cmd = 1'b1; addr = 4'd3;
        @(negedge clk);
        pulse_cmd = 1'b0;
        check("R9 first payload", payload, 32'hA1B2_C3D4);
        @(negedge clk);
        @(negedge clk);
        check("R9 no early update", 32'(update_req), 32'd0);
        pulse_cmd = 1'b1; addr = 4'd7;
        @(negedge clk);
        pulse_cmd = 1'b0;
        check("R9 new payload", payload, 32'h6666_7777);
        check("R9 valid again", 32'(payload_valid), 32'd1);
        for (int i = 1; i < DELAY; i++) begin
            @(negedge clk);
            check("R9 update suppressed", 32'(update_req), 32'd0);
        end
        @(negedge clk);
        check("R9 update after restart", 32'(update_req), 32'd1);
        for (int i = 0; i < DELAY + 2; i++) begin
            @(negedge clk);
            check("R9 single update", 32'(update_req), 32'd0);
        end
    endtask

    task automatic t_same_cycle();
        load(1'b0, 1'b0, 4'd3, 16'hCAFE);
        load(1'b0, 1'b1, 4'd3, 16'hBEEF);
        load_cmd = 1'b1; wr_en = 1'b1; set_cur = 1'b1; pulse_cmd = 1'b1; addr = 4'd3;
        @(negedge clk);
        load_cmd = 1'b0; wr_en = 1'b0; set_cur = 1'b0; pulse_cmd = 1'b0;
        check("R10 old contents", payload, 32'hA1B2_C3D4);
        repeat (DELAY + 1) @(negedge clk);
        pulse_check("R10 new contents next pulse", 4'd3, 32'hBEEF_CAFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_read();
        t_halves_isolated();
        t_ignored();
        t_retrigger();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule